// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block collects every exception request aimed at the CPU and returns one 16-bit vector address when the CPU asks for it. The requests are of three kinds. A parameterized set of I-maskable peripheral lines each has its own local enable. Software interrupt, illegal-opcode trap and an X-maskable request are not gated by the I bit. Three reset causes come in one-hot.

Priority is not stored anywhere. It follows from the vector address: the candidate with the numerically highest address wins. The choice is made at the moment the CPU strobes a vector request, so a stronger request that arrives after the pending line rose still takes the slot.

The upper address byte comes from a software-writable base register. Reset vectors and debug mode force that byte to 0xFF. The chosen vector is registered on the strobe and held until the next strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the base register reads back 0xFF on `base_rdata_o`, `vec_addr_o` is 0xFFFE and `pending_o` follows only the inputs.
- R2: When `base_we_i` is high at a clock edge, `base_rdata_o` shows `base_wdata_i` from that edge on. A strobe at the same edge still uses the old base.
- R3: An interrupt vector is {base, low byte}. The low byte is 0x80+2k for I-maskable line k (k from 0 to N_IRQ-1, N_IRQ at most 58), 0xF4 for the X-maskable request, 0xF6 for software interrupt and 0xF8 for trap.
- R4: I-maskable line k is a candidate only when `irq_req_i[k]` and `irq_en_i[k]` are both set, `i_mask_i` is 0, and none of `swi_req_i`, `trap_req_i` or `xirq_req_i` is high.
- R5: Among the candidates the one with the highest vector address wins. Trap beats software interrupt, which beats X-maskable, which beats every I-maskable line. Among I-maskable lines the higher index wins.
- R6: The X-maskable request is a candidate only when `x_mask_i` is 0. The state of `i_mask_i` does not matter to it.
- R7: Any set bit of `rst_cause_i` outranks everything else. Bit 2 gives 0xFFFE, bit 1 gives 0xFFFC and bit 0 gives 0xFFFA, with bit 2 winning over bit 1 and bit 1 over bit 0. The base register has no effect on these vectors.
- R8: While `dbg_active_i` is high, the upper byte of every vector is 0xFF, whatever the base register holds.
- R9: `vec_addr_o` is loaded at a clock edge where `vec_req_i` and `pending_o` are both high. Otherwise it holds its value, which covers a strobe with nothing pending.
- R10: `pending_o` is the combinational OR of all qualified candidates. The winner is chosen from the inputs present at the strobe edge, not from those present when `pending_o` first rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | N_IRQ | I-maskable request lines |
| irq_en_i | input | N_IRQ | Local enable per I-maskable line |
| swi_req_i | input | 1 | Software interrupt request |
| trap_req_i | input | 1 | Illegal-opcode trap request |
| xirq_req_i | input | 1 | X-maskable request |
| i_mask_i | input | 1 | CPU I mask bit (1 = masked) |
| x_mask_i | input | 1 | CPU X mask bit (1 = masked) |
| dbg_active_i | input | 1 | Debug firmware is running |
| rst_cause_i | input | 3 | One-hot reset cause (bit 2 / 1 / 0 select FFFE / FFFC / FFFA) |
| base_we_i | input | 1 | Base register write enable |
| base_wdata_i | input | 8 | Base register write data |
| base_rdata_o | output | 8 | Base register current value |
| vec_req_i | input | 1 | CPU vector-fetch strobe |
| pending_o | output | 1 | Some qualified request is present |
| vec_addr_o | output | 16 | Registered vector address |

## Verification
The bench goes after late arbitration. A trap raised a few cycles after an I-maskable line must take the strobe; a design that latched the winner early would return the peripheral vector. It checks that a pending X-maskable request blocks I-maskable lines even while the X bit masks it. A design that keyed the block on the qualified request would raise `pending_o` there. Reset and debug vectors are checked under a non-0xFF base; a design that let the base reach them would hand out vectors in the wrong page. The bench also strobes with nothing pending and strobes in the same cycle as a base write, where a wrong design would change the held vector or use the new base too early.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam logic [7:0]  BASE_RST    = 8'hFF;
  localparam logic [7:0]  HI_FIXED    = 8'hFF;
  localparam logic [7:0]  LO_IRQ_BASE = 8'h80;
  localparam logic [7:0]  LO_XIRQ     = 8'hF4;
  localparam logic [7:0]  LO_SWI      = 8'hF6;
  localparam logic [7:0]  LO_TRAP     = 8'hF8;
  localparam logic [15:0] VEC_RST_VAL = 16'hFFFE;
  localparam int unsigned RST_CAUSES  = 3;
  localparam int unsigned MAX_IRQ     = 58;

  typedef struct packed {
    logic       valid;
    logic       fixed_hi;
    logic [7:0] lo;
  } pick_t;

  function automatic logic [7:0] irq_lo(int unsigned k);
    return LO_IRQ_BASE + 8'(2 * k);
  endfunction

  function automatic logic [7:0] rst_lo(logic [RST_CAUSES-1:0] c);
    if (c[2])      return 8'hFE;
    else if (c[1]) return 8'hFC;
    else           return 8'hFA;
  endfunction
endpackage

// File: rtl/irq_base_reg.sv
module irq_base_reg
  import irq_vec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= BASE_RST;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_IRQ = 16
) (
  input  logic [N_IRQ-1:0]      irq_req_i,
  input  logic [N_IRQ-1:0]      irq_en_i,
  input  logic                  swi_req_i,
  input  logic                  trap_req_i,
  input  logic                  xirq_req_i,
  input  logic                  i_mask_i,
  input  logic                  x_mask_i,
  input  logic [RST_CAUSES-1:0] rst_cause_i,
  output logic [N_IRQ-1:0]      irq_cand_o,
  output logic                  xirq_cand_o,
  output logic                  any_o
);
  logic nmi_block;

  // raw X request blocks I-maskable lines even when X bit masks it
  assign nmi_block   = swi_req_i | trap_req_i | xirq_req_i;
  assign irq_cand_o  = (!i_mask_i && !nmi_block) ? (irq_req_i & irq_en_i) : '0;
  assign xirq_cand_o = xirq_req_i & ~x_mask_i;
  assign any_o       = (|rst_cause_i) | trap_req_i | swi_req_i | xirq_cand_o | (|irq_cand_o);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_IRQ = 16
) (
  input  logic [N_IRQ-1:0]      irq_cand_i,
  input  logic                  swi_i,
  input  logic                  trap_i,
  input  logic                  xirq_cand_i,
  input  logic [RST_CAUSES-1:0] rst_cause_i,
  output pick_t                 pick_o
);
  logic [7:0] lo_tab [N_IRQ];

  for (genvar k = 0; k < N_IRQ; k++) begin : g_lo
    assign lo_tab[k] = irq_lo(k);
  end

  // later assignments carry higher addresses and override earlier ones
  always_comb begin
    pick_o = '0;
    for (int unsigned k = 0; k < N_IRQ; k++) begin
      if (irq_cand_i[k]) pick_o = '{valid: 1'b1, fixed_hi: 1'b0, lo: lo_tab[k]};
    end
    if (xirq_cand_i)      pick_o = '{valid: 1'b1, fixed_hi: 1'b0, lo: LO_XIRQ};
    if (swi_i)            pick_o = '{valid: 1'b1, fixed_hi: 1'b0, lo: LO_SWI};
    if (trap_i)           pick_o = '{valid: 1'b1, fixed_hi: 1'b0, lo: LO_TRAP};
    if (|rst_cause_i)     pick_o = '{valid: 1'b1, fixed_hi: 1'b1, lo: rst_lo(rst_cause_i)};
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_IRQ = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_IRQ-1:0]      irq_req_i,
  input  logic [N_IRQ-1:0]      irq_en_i,
  input  logic                  swi_req_i,
  input  logic                  trap_req_i,
  input  logic                  xirq_req_i,
  input  logic                  i_mask_i,
  input  logic                  x_mask_i,
  input  logic                  dbg_active_i,
  input  logic [2:0]            rst_cause_i,
  input  logic                  base_we_i,
  input  logic [7:0]            base_wdata_i,
  output logic [7:0]            base_rdata_o,
  input  logic                  vec_req_i,
  output logic                  pending_o,
  output logic [15:0]           vec_addr_o
);
  logic [N_IRQ-1:0] irq_cand;
  logic             xirq_cand;
  pick_t            pick;
  logic [7:0]       hi_byte;
  logic [7:0]       base_q;

  if (N_IRQ < 1 || N_IRQ > MAX_IRQ) begin : g_bad_n
    $error("N_IRQ out of range");
  end

  irq_base_reg u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .wdata_i (base_wdata_i),
    .q_o     (base_q)
  );

  irq_qualify #(.N_IRQ(N_IRQ)) u_qual (
    .irq_req_i   (irq_req_i),
    .irq_en_i    (irq_en_i),
    .swi_req_i   (swi_req_i),
    .trap_req_i  (trap_req_i),
    .xirq_req_i  (xirq_req_i),
    .i_mask_i    (i_mask_i),
    .x_mask_i    (x_mask_i),
    .rst_cause_i (rst_cause_i),
    .irq_cand_o  (irq_cand),
    .xirq_cand_o (xirq_cand),
    .any_o       (pending_o)
  );

  irq_prio_pick #(.N_IRQ(N_IRQ)) u_pick (
    .irq_cand_i  (irq_cand),
    .swi_i       (swi_req_i),
    .trap_i      (trap_req_i),
    .xirq_cand_i (xirq_cand),
    .rst_cause_i (rst_cause_i),
    .pick_o      (pick)
  );

  assign hi_byte      = (pick.fixed_hi || dbg_active_i) ? HI_FIXED : base_q;
  assign base_rdata_o = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      vec_addr_o <= VEC_RST_VAL;
    else if (vec_req_i && pick.valid) vec_addr_o <= {hi_byte, pick.lo};
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        swi_req_i,
  input logic        trap_req_i,
  input logic        xirq_req_i,
  input logic        i_mask_i,
  input logic        x_mask_i,
  input logic        dbg_active_i,
  input logic [2:0]  rst_cause_i,
  input logic        base_we_i,
  input logic [7:0]  base_wdata_i,
  input logic [7:0]  base_rdata_o,
  input logic        vec_req_i,
  input logic        pending_o,
  input logic [15:0] vec_addr_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_base_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(base_we_i) |-> base_rdata_o == $past(base_wdata_i));

  p_vec_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(vec_req_i && pending_o) |-> $stable(vec_addr_o));

  p_reset_page_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(vec_req_i && (rst_cause_i != 3'b000)) |->
      vec_addr_o[15:8] == 8'hFF && vec_addr_o[7:0] >= 8'hFA && !vec_addr_o[0]);

  p_dbg_page_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(vec_req_i && pending_o && dbg_active_i) |-> vec_addr_o[15:8] == 8'hFF);

  p_imask_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    i_mask_i && !swi_req_i && !trap_req_i && !xirq_req_i && rst_cause_i == 3'b000 |-> !pending_o);

  p_xmask_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_mask_i && xirq_req_i && !swi_req_i && !trap_req_i && rst_cause_i == 3'b000 |-> !pending_o);

  p_nmi_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swi_req_i || trap_req_i || rst_cause_i != 3'b000 |-> pending_o);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .swi_req_i    (swi_req_i),
  .trap_req_i   (trap_req_i),
  .xirq_req_i   (xirq_req_i),
  .i_mask_i     (i_mask_i),
  .x_mask_i     (x_mask_i),
  .dbg_active_i (dbg_active_i),
  .rst_cause_i  (rst_cause_i),
  .base_we_i    (base_we_i),
  .base_wdata_i (base_wdata_i),
  .base_rdata_o (base_rdata_o),
  .vec_req_i    (vec_req_i),
  .pending_o    (pending_o),
  .vec_addr_o   (vec_addr_o)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int N = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0, irq_en = '0;
  logic          swi = 0, trap = 0, xirq = 0, im = 1, xm = 1, dbg = 0;
  logic [2:0]    rcause = '0;
  logic          we = 0;
  logic [7:0]    wd = '0;
  logic [7:0]    rdata;
  logic          vreq = 0;
  logic          pend;
  logic [15:0]   vec;

  irq_vector_ctrl #(.N_IRQ(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .irq_en_i(irq_en),
    .swi_req_i(swi), .trap_req_i(trap), .xirq_req_i(xirq), .i_mask_i(im),
    .x_mask_i(xm), .dbg_active_i(dbg), .rst_cause_i(rcause), .base_we_i(we),
    .base_wdata_i(wd), .base_rdata_o(rdata), .vec_req_i(vreq),
    .pending_o(pend), .vec_addr_o(vec)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [15:0] v; string tag; } item_t;
  item_t sb[$];
  logic [15:0] m_vec = 16'hFFFE;
  logic [7:0]  m_base = 8'hFF;

  function automatic logic model_pend();
    logic blk = swi | trap | xirq;
    return (|rcause) | trap | swi | (xirq & ~xm) | (!im && !blk && |(irq_req & irq_en));
  endfunction

  function automatic logic [15:0] model_vec();
    logic [7:0] hi = dbg ? 8'hFF : m_base;
    if (rcause[2]) return 16'hFFFE;
    if (rcause[1]) return 16'hFFFC;
    if (rcause[0]) return 16'hFFFA;
    if (trap) return {hi, 8'hF8};
    if (swi)  return {hi, 8'hF6};
    if (xirq && !xm) return {hi, 8'hF4};
    if (!im && !xirq) begin
      for (int k = N - 1; k >= 0; k--)
        if (irq_req[k] && irq_en[k]) return {hi, 8'(8'h80 + 2 * k)};
    end
    return m_vec;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    irq_req = '0; irq_en = '0; swi = 0; trap = 0; xirq = 0;
    im = 1; xm = 1; dbg = 0; rcause = '0;
  endtask

  // driver: pending check then strobe; expected pushed to scoreboard
  task automatic strobe(string tag);
    item_t it;
    @(negedge clk);
    chk({tag, " pending"}, {15'd0, pend}, {15'd0, model_pend()});
    it.v = model_vec(); it.tag = tag;
    m_vec = it.v;
    sb.push_back(it);
    vreq = 1;
    @(negedge clk);
    vreq = 0;
  endtask

  task automatic write_base(logic [7:0] d);
    @(negedge clk); we = 1; wd = d;
    @(negedge clk); we = 0;
    m_base = d;
    chk("R2 base readback", {8'h00, rdata}, {8'h00, d});
  endtask

  // monitor
  always @(posedge clk) begin
    if (vreq && rst_n) begin
      item_t it;
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        chk(it.tag, vec, it.v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 base reset", {8'h00, rdata}, 16'h00FF);
    chk("R1 vec reset", vec, 16'hFFFE);
    chk("R1 pending idle", {15'd0, pend}, 16'd0);

    quiet(); im = 0; irq_req[3] = 1; irq_en[3] = 1;
    strobe("R3 irq3 offset");
    quiet(); im = 0; irq_req[3] = 1; irq_en[3] = 1; irq_req[10] = 1; irq_en[10] = 1;
    strobe("R5 irq10 over irq3");
    quiet(); im = 0; irq_req[15] = 1; irq_en[15] = 0;
    strobe("R4 local enable off, R9 hold");
    quiet(); im = 1; irq_req[5] = 1; irq_en[5] = 1;
    strobe("R4 I bit masks");
    quiet(); im = 0; irq_req[5] = 1; irq_en[5] = 1; swi = 1;
    strobe("R5 swi over irq");
    quiet(); swi = 1; trap = 1;
    strobe("R5 trap over swi");
    quiet(); im = 1; xm = 0; xirq = 1; irq_req[1] = 1; irq_en[1] = 1;
    strobe("R6 xirq under I mask");
    quiet(); im = 0; xm = 1; xirq = 1; irq_req[1] = 1; irq_en[1] = 1;
    strobe("R4 R6 masked xirq blocks irq");

    write_base(8'h40);
    quiet(); im = 0; irq_req[0] = 1; irq_en[0] = 1;
    strobe("R3 base 0x40 irq0");
    quiet(); rcause = 3'b001; trap = 1;
    strobe("R7 cause0 FFFA");
    quiet(); rcause = 3'b011;
    strobe("R7 cause1 FFFC");
    quiet(); rcause = 3'b111;
    strobe("R7 cause2 FFFE");
    quiet(); dbg = 1; im = 0; irq_req[2] = 1; irq_en[2] = 1;
    strobe("R8 debug page");

    // late arbitration: trap appears after pending rose
    quiet(); im = 0; irq_req[2] = 1; irq_en[2] = 1;
    @(negedge clk);
    chk("R10 pending from irq", {15'd0, pend}, 16'd1);
    repeat (3) @(negedge clk);
    trap = 1;
    strobe("R10 late trap wins");

    // base write in strobe cycle uses old base
    quiet(); im = 0; irq_req[7] = 1; irq_en[7] = 1;
    @(negedge clk);
    we = 1; wd = 8'h22; vreq = 1;
    begin
      item_t it; it.v = {m_base, 8'h8E}; it.tag = "R2 old base at strobe";
      sb.push_back(it); m_vec = it.v;
    end
    @(negedge clk); we = 0; vreq = 0; m_base = 8'h22;
    chk("R2 new base readback", {8'h00, rdata}, 16'h0022);
    strobe("R2 new base used");

    quiet();
    strobe("R9 nothing pending keeps vec");

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", 16'(sb.size()), 16'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule